// File: doc/BRIEF.md
# Time Base and Decrementer

This block holds a 64-bit up-counting time base and a 32-bit down-counting decrementer. Both move by one step on every clock cycle where the tick-enable input is high. The source of the tick is a divided reference clock or a plain clock enable. Software reaches the two time-base halves and the decrementer through a single-cycle register port. Writes are strobed, and reads are combinational from the selected address.

The decrementer raises a sticky pending flag whenever its bit 31 goes from 0 to 1. This happens in two ways: counting down past zero, or a software write that puts a negative value over a non-negative one. A clear strobe drops the flag. A mode input selects a real-time-clock view, in which the low time-base word is masked to a reduced field on both reads and writes, and the upper word is unchanged.

The port is a plain control interface with no back-pressure. A write completes in the cycle its strobe is sampled. Read data follows the address in the same cycle.

Top module: `timebase_decr`

## Requirements
- R1: After reset the time base reads 0 in both halves, the decrementer reads 0xFFFFFFFF and the pending flag is low.
- R2: With tick-enable low and no write, the time base and the decrementer hold their values.
- R3: Each tick adds one to the 64-bit time base. When the low half steps from 0xFFFFFFFF, the carry reaches the high half on the same tick.
- R4: A write to address 0 (low half) leaves the high half unchanged. A write to address 1 (high half) leaves the low half unchanged.
- R5: Each tick subtracts one from the decrementer (address 2).
- R6: A tick that moves the decrementer from 0 to 0xFFFFFFFF sets the pending flag, which is visible on the cycle after that tick.
- R7: A write to the decrementer sets the pending flag only when the old value has bit 31 clear and the new value has bit 31 set.
- R8: The pending flag stays set until a clear strobe. If a new event and a clear arrive in the same cycle, the flag stays set.
- R9: With the real-time-clock mode input high, low-half reads return the value ANDed with 0x3FFFFF80, and low-half writes store the data ANDed with 0x3FFFFF80. High-half access is unaffected.
- R10: Address 3 reads as zero, and writes to it change no state.
- R11: A write that coincides with a tick loads the written value. The written register does not also count in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable for both counters |
| rtc_mode_i | input | 1 | Selects the masked real-time-clock low-word view |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 2 | Register select: 0 low half, 1 high half, 2 decrementer, 3 unused |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the addressed register |
| irq_clr_i | input | 1 | Clears the pending decrementer flag |
| dec_irq_o | output | 1 | Pending decrementer exception flag |

## Verification
A bad carry or a bad increment in the time base shows up on the next read of either half. A register that is off by one or loses its carry stays wrong from that point on, because the counter never resynchronises. A wrong decrementer value can hide until the count crosses zero. The bench therefore loads small values and counts through the boundary, so that an early, late or missing flag appears on the cycle after the crossing tick. Write-side sign detection is checked against both old-value polarities, because a detector that looks only at the new value differs only when the old value is already negative.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wr_lo;
    logic wr_hi;
    logic wr_dec;
  } wr_strobes_t;
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
  parameter int unsigned TB_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [TB_W/2-1:0] wdata,
  output logic [TB_W-1:0]   tb_q
);
  localparam int unsigned HALF_W = TB_W / 2;

  logic [HALF_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              carry;

  // carry only when the low half really counts this cycle
  assign carry = tick && !wr_lo && (&lo_q);

  always_comb begin
    lo_d = lo_q;
    if (wr_lo)     lo_d = wdata;
    else if (tick) lo_d = lo_q + HALF_W'(1);
    hi_d = hi_q;
    if (wr_hi)      hi_d = wdata;
    else if (carry) hi_d = hi_q + HALF_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign tb_q = {hi_q, lo_q};
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int unsigned DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [DEC_W-1:0] wdata,
  input  logic             clr,
  output logic [DEC_W-1:0] dec_q,
  output logic             pend_q
);
  localparam int unsigned SIGN = DEC_W - 1;

  logic [DEC_W-1:0] dec_d;
  logic             sign_rise;

  always_comb begin
    dec_d = dec_q;
    if (wr)        dec_d = wdata;
    else if (tick) dec_d = dec_q - DEC_W'(1);
  end

  // one detector covers both counting and software writes
  assign sign_rise = !dec_q[SIGN] && dec_d[SIGN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      dec_q <= dec_d;
      if (sign_rise)  pend_q <= 1'b1;
      else if (clr)   pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tbd_regport.sv
module tbd_regport
  import tbd_pkg::*;
#(
  parameter int unsigned         DW       = 32,
  parameter logic [DW-1:0]       RTC_MASK = 32'h3FFF_FF80
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rtc_mode,
  input  logic [2*DW-1:0]   tb_val,
  input  logic [DW-1:0]     dec_val,
  output wr_strobes_t       strb,
  output logic [DW-1:0]     wdata_lo,
  output logic [DW-1:0]     rd_data
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_comb begin
    strb = '0;
    if (wr_en) begin
      unique case (sel)
        SEL_TB_LO: strb.wr_lo  = 1'b1;
        SEL_TB_HI: strb.wr_hi  = 1'b1;
        SEL_DEC:   strb.wr_dec = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

  assign wdata_lo = rtc_mode ? (wr_data & RTC_MASK) : wr_data;

  always_comb begin
    unique case (sel)
      SEL_TB_LO: rd_data = rtc_mode ? (tb_val[DW-1:0] & RTC_MASK) : tb_val[DW-1:0];
      SEL_TB_HI: rd_data = tb_val[2*DW-1:DW];
      SEL_DEC:   rd_data = dec_val;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/timebase_decr.sv
module timebase_decr
  import tbd_pkg::*;
#(
  parameter int unsigned         DW       = WORD_W,
  parameter logic [DW-1:0]       RTC_MASK = 32'h3FFF_FF80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rtc_mode_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              irq_clr_i,
  output logic              dec_irq_o
);
  localparam int unsigned TB_W = 2 * DW;

  wr_strobes_t      strb;
  logic [DW-1:0]    wdata_lo;
  logic [TB_W-1:0]  tb_w;
  logic [DW-1:0]    dec_w;
  logic [DW-1:0]    hi_wdata;

  tbd_regport #(.DW(DW), .RTC_MASK(RTC_MASK)) u_port (
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .wr_data  (wr_data_i),
    .rtc_mode (rtc_mode_i),
    .tb_val   (tb_w),
    .dec_val  (dec_w),
    .strb     (strb),
    .wdata_lo (wdata_lo),
    .rd_data  (rd_data_o)
  );

  // one data path serves both halves; the low half gets the masked copy
  assign hi_wdata = strb.wr_lo ? wdata_lo : wr_data_i;

  tbd_timebase #(.TB_W(TB_W)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_i),
    .wr_lo (strb.wr_lo),
    .wr_hi (strb.wr_hi),
    .wdata (hi_wdata),
    .tb_q  (tb_w)
  );

  tbd_decrementer #(.DEC_W(DW)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_i),
    .wr     (strb.wr_dec),
    .wdata  (wr_data_i),
    .clr    (irq_clr_i),
    .dec_q  (dec_w),
    .pend_q (dec_irq_o)
  );
endmodule

// File: rtl/timebase_decr_chk.sv
module timebase_decr_chk #(
  parameter int unsigned DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_i,
  input logic            rtc_mode_i,
  input logic            wr_en_i,
  input logic [1:0]      addr_i,
  input logic [DW-1:0]   rd_data_o,
  input logic            irq_clr_i,
  input logic            dec_irq_o,
  input logic [2*DW-1:0] tb_q,
  input logic [DW-1:0]   dec_q
);
  logic tb_wr, dec_wr;
  assign tb_wr  = wr_en_i && (addr_i == 2'd0 || addr_i == 2'd1);
  assign dec_wr = wr_en_i && (addr_i == 2'd2);

  // R2
  tb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !tb_wr |=> $stable(tb_q));

  // R3
  tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !tb_wr |=> tb_q == $past(tb_q) + 64'd1);

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !dec_wr |=> dec_q == $past(dec_q) - 32'd1);

  // R6
  dec_wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !dec_wr && dec_q == '0 |=> dec_irq_o);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq_o && !irq_clr_i |=> dec_irq_o);

  // R9
  rtc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_mode_i && addr_i == 2'd0 |-> (rd_data_o & ~32'h3FFF_FF80) == '0);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_i == 2'd3 |-> rd_data_o == '0);
endmodule

bind timebase_decr timebase_decr_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .rtc_mode_i (rtc_mode_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .rd_data_o  (rd_data_o),
  .irq_clr_i  (irq_clr_i),
  .dec_irq_o  (dec_irq_o),
  .tb_q       (tb_w),
  .dec_q      (dec_w)
);

// File: tb/timebase_decr_bench.sv
module timebase_decr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        rtc_mode_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_clr_i = 1'b0;
  logic        dec_irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timebase_decr u_timebase_decr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rtc_mode_i(rtc_mode_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .irq_clr_i(irq_clr_i), .dec_irq_o(dec_irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); check("R1 lo", v, 32'h0);
    rd(2'd1, v); check("R1 hi", v, 32'h0);
    rd(2'd2, v); check("R1 dec", v, 32'hFFFF_FFFF);
    check("R1 irq", {31'd0, dec_irq_o}, 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R2 lo held", v, 32'h0);
    rd(2'd2, v); check("R2 dec held", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_count();
    logic [31:0] v;
    ticks(5);
    rd(2'd0, v); check("R3 lo count", v, 32'd5);
    rd(2'd2, v); check("R5 dec count", v, 32'hFFFF_FFFA);
  endtask

  task automatic t_carry();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFE);
    wr(2'd1, 32'd5);
    ticks(3);
    rd(2'd0, v); check("R3 lo wrap", v, 32'd1);
    rd(2'd1, v); check("R3 hi carry", v, 32'd6);
  endtask

  task automatic t_halves();
    logic [31:0] v;
    wr(2'd0, 32'h0000_1234);
    rd(2'd1, v); check("R4 hi kept", v, 32'd6);
    wr(2'd1, 32'h0000_00AA);
    rd(2'd0, v); check("R4 lo kept", v, 32'h0000_1234);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    tick_i = 1'b1;
    wr(2'd0, 32'h0000_0100);
    tick_i = 1'b0;
    rd(2'd0, v); check("R11 lo write wins", v, 32'h0000_0100);
    tick_i = 1'b1;
    wr(2'd2, 32'h0000_0040);
    tick_i = 1'b0;
    rd(2'd2, v); check("R11 dec write wins", v, 32'h0000_0040);
  endtask

  task automatic t_dec_zero();
    logic [31:0] v;
    wr(2'd2, 32'd2);
    check("R7 positive write no irq", {31'd0, dec_irq_o}, 32'd0);
    ticks(2);
    rd(2'd2, v); check("R5 dec at zero", v, 32'd0);
    check("R6 no irq at zero", {31'd0, dec_irq_o}, 32'd0);
    ticks(1);
    rd(2'd2, v); check("R6 dec wrapped", v, 32'hFFFF_FFFF);
    check("R6 irq on wrap", {31'd0, dec_irq_o}, 32'd1);
    repeat (3) @(negedge clk);
    check("R8 irq sticky", {31'd0, dec_irq_o}, 32'd1);
    irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
    check("R8 irq cleared", {31'd0, dec_irq_o}, 32'd0);
  endtask

  task automatic t_write_neg();
    wr(2'd2, 32'h8000_0000);
    check("R7 neg over neg", {31'd0, dec_irq_o}, 32'd0);
    wr(2'd2, 32'h0000_0010);
    wr(2'd2, 32'h8000_0005);
    check("R7 neg over pos", {31'd0, dec_irq_o}, 32'd1);
    irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
    wr(2'd2, 32'd0);
    irq_clr_i = 1'b1;
    wr(2'd2, 32'h8000_0000);
    irq_clr_i = 1'b0;
    check("R8 set beats clear", {31'd0, dec_irq_o}, 32'd1);
    irq_clr_i = 1'b1; @(negedge clk); irq_clr_i = 1'b0;
  endtask

  task automatic t_rtc();
    logic [31:0] v;
    rtc_mode_i = 1'b1;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R9 rtc lo read", v, 32'h3FFF_FF80);
    wr(2'd1, 32'h0000_0077);
    rd(2'd1, v); check("R9 rtc hi plain", v, 32'h0000_0077);
    rtc_mode_i = 1'b0;
    rd(2'd0, v); check("R9 rtc lo stored masked", v, 32'h3FFF_FF80);
    wr(2'd0, 32'h0000_0013);
    rtc_mode_i = 1'b1;
    rd(2'd0, v); check("R9 rtc read mask", v, 32'h0000_0000);
    rtc_mode_i = 1'b0;
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, v); check("R10 rsvd reads zero", v, 32'h0);
    rd(2'd0, v); check("R10 lo untouched", v, 32'h0000_0013);
    rd(2'd1, v); check("R10 hi untouched", v, 32'h0000_0077);
    rd(2'd2, v); check("R10 dec untouched", v, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_count();
    t_carry();
    t_halves();
    t_same_cycle();
    t_dec_zero();
    t_write_neg();
    t_rtc();
    t_reserved();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule